// File: doc/BRIEF.md
# Fractional Audio Sample-Strobe Generator

This block produces audio sample strobes at rates from 8 kHz to 48 kHz from one of two reference tick streams, one at 44.1 kHz and one at 48 kHz. Each generator channel keeps an error accumulator. On every tick of its chosen reference, the accumulator gains a programmed increment. When the running total reaches a programmed modulus, the channel emits a one-cycle strobe and subtracts the modulus. Over a long run the strobe rate is therefore increment × reference / modulus. With an increment of 4, the modulus is 4 × reference / wanted rate. Software picks whichever reference leaves the smaller remainder when divided by the wanted rate.

The block holds `NUM_GEN` independent channels (two by default), for example one for playback and one for capture. Each channel is programmed by a single write. The write carries a 32-bit configuration word and a reference-select bit. In the word, the low half holds the increment. The high half holds the modulus in an offset form: (increment − modulus − 1) taken modulo 2^16. The reference ticks come from outside the block. They are one-cycle pulses in the system clock domain.

Top module: `bres_clkgen`

## Requirements
- R1: After reset every channel drives its strobe low, its accumulator is zero and its increment is zero, so no strobes appear until the channel is written.
- R2: A write to channel c (bit c of `cfg_wr`) loads increment = `cfg_word[15:0]` and modulus = (increment − `cfg_word[31:16]` − 1) mod 2^16. It also latches `cfg_sel`, where 1 selects the 44.1 kHz tick and 0 selects the 48 kHz tick.
- R3: Only ticks on the channel's selected reference advance its accumulator. Ticks on the other reference have no effect on the strobe or on the accumulator.
- R4: Consider a channel with nonzero increment and modulus ≥ increment. Each counted tick adds the increment. If the sum is ≥ the modulus, the channel strobes and keeps sum − modulus; otherwise it keeps the sum. Over N ticks from a cleared state, the channel therefore strobes floor(N·inc/mod) times.
- R5: The strobe is registered. It is high for exactly the one clock cycle that follows the clock edge that sampled the qualifying tick, and low in every other cycle.
- R6: A configuration write clears that channel's accumulator and strobe. A tick present in the same cycle as the write is ignored.
- R7: When the increment is nonzero and the modulus is smaller than the increment, the channel strobes on every counted tick and its accumulator stays at zero.
- R8: While a channel's increment is zero, its strobe never rises.
- R9: Channels are independent. Writes to one channel, and the counting in one channel, do not change another channel's strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | NUM_GEN | One write-enable bit per channel |
| cfg_sel | input | 1 | Reference select latched on a write (1 = 44.1 kHz tick, 0 = 48 kHz tick) |
| cfg_word | input | 32 | Increment in [15:0], offset-encoded modulus in [31:16] |
| tick_44k1 | input | 1 | One-cycle pulse at the 44.1 kHz reference rate |
| tick_48k | input | 1 | One-cycle pulse at the 48 kHz reference rate |
| strobe_o | output | NUM_GEN | One-cycle sample strobe per channel |

## Verification
The accumulator is exercised with patterns chosen to separate different faults:
- An integer ratio (48 kHz to 8 kHz, modulus 24) confirms a strobe on exactly every sixth tick.
- A fractional ratio (44.1 kHz reference with modulus 5) makes the remainder carry from one strobe to the next, so a fault in the subtract-and-keep step changes the strobe pattern.
- A modulus equal to the increment must strobe on every tick.
- A modulus below the increment tests the degenerate path, and an increment of zero tests the idle case.
- Ticks on the wrong reference, and a tick landing in the same cycle as a write, must produce no strobe.
- A mid-count rewrite is placed so that a missing accumulator clear would produce an extra strobe.
- Running two channels at once, each on its own reference, detects any cross-talk between channels.

// File: rtl/bres_pkg.sv
package bres_pkg;

    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int ACC_W   = FIELD_W + 1;

    typedef enum logic { REF_48K = 1'b0, REF_44K1 = 1'b1 } ref_sel_e;

    typedef struct packed {
        ref_sel_e           src;
        logic [FIELD_W-1:0] inc;
        logic [FIELD_W-1:0] modulus;
    } gen_cfg_t;

    // Unpack a configuration word: the upper half holds (inc - mod - 1).
    function automatic gen_cfg_t decode_cfg(input logic [WORD_W-1:0] word,
                                            input logic sel);
        gen_cfg_t c;
        c.src     = ref_sel_e'(sel);
        c.inc     = word[FIELD_W-1:0];
        c.modulus = word[FIELD_W-1:0] - word[WORD_W-1:FIELD_W] - FIELD_W'(1);
        return c;
    endfunction

endpackage

// File: rtl/bres_cfg_reg.sv
module bres_cfg_reg
    import bres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [WORD_W-1:0] word_i,
    output gen_cfg_t          cfg_o,
    output logic              clr_o
);
    gen_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_i)
            cfg_q <= decode_cfg(word_i, sel_i);
    end

    assign cfg_o = cfg_q;
    assign clr_o = wr_i;

    // R1: increment is zero straight after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> cfg_q.inc == '0);
endmodule

// File: rtl/bres_tick_select.sv
module bres_tick_select
    import bres_pkg::*;
(
    input  ref_sel_e src_i,
    input  logic     tick_44k1_i,
    input  logic     tick_48k_i,
    output logic     tick_o
);
    always_comb begin
        unique case (src_i)
            REF_44K1: tick_o = tick_44k1_i;
            default:  tick_o = tick_48k_i;
        endcase
    end
endmodule

// File: rtl/bres_accum.sv
module bres_accum
    import bres_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_i,
    input  logic     tick_i,
    input  gen_cfg_t cfg_i,
    output logic     strobe_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] mod_ext;
    logic             idle;
    logic             degen;
    logic             hit;
    logic             strobe_q;

    always_comb begin
        mod_ext = {1'b0, cfg_i.modulus};
        sum     = acc_q + {1'b0, cfg_i.inc};
        idle    = (cfg_i.inc == '0);
        degen   = !idle && (cfg_i.modulus < cfg_i.inc);
        hit     = (sum >= mod_ext);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_q    <= '0;
            strobe_q <= 1'b0;
        end else if (tick_i) begin
            if (idle) begin
                strobe_q <= 1'b0;
            end else if (degen) begin
                acc_q    <= '0;
                strobe_q <= 1'b1;
            end else if (hit) begin
                acc_q    <= sum - mod_ext;
                strobe_q <= 1'b1;
            end else begin
                acc_q    <= sum;
                strobe_q <= 1'b0;
            end
        end else begin
            strobe_q <= 1'b0;
        end
    end

    assign strobe_o = strobe_q;

    // R5: a strobe is always caused by a counted tick one edge earlier
    a_r5_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> $past(tick_i && !clr_i));
    // R4: accumulator stays below the modulus in normal operation
    a_r4_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.inc != '0 && cfg_i.modulus >= cfg_i.inc) |-> acc_q < mod_ext);
    // R6: a write leaves the accumulator and strobe cleared
    a_r6_clear_on_write: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (acc_q == '0 && !strobe_q));
    // R7: degenerate modulus keeps the accumulator at zero
    a_r7_degen_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.inc != '0 && cfg_i.modulus < cfg_i.inc) |-> acc_q == '0);
    // R8: no strobe while the increment is zero
    a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.inc == '0) |-> !strobe_q);
endmodule

// File: rtl/bres_clkgen.sv
module bres_clkgen
    import bres_pkg::*;
#(
    parameter int NUM_GEN = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GEN-1:0] cfg_wr,
    input  logic               cfg_sel,
    input  logic [WORD_W-1:0]  cfg_word,
    input  logic               tick_44k1,
    input  logic               tick_48k,
    output logic [NUM_GEN-1:0] strobe_o
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        gen_cfg_t cfg;
        logic     clr;
        logic     tick;

        bres_cfg_reg u_cfg (
            .clk    (clk),
            .rst    (rst),
            .wr_i   (cfg_wr[g]),
            .sel_i  (cfg_sel),
            .word_i (cfg_word),
            .cfg_o  (cfg),
            .clr_o  (clr)
        );

        bres_tick_select u_sel (
            .src_i       (cfg.src),
            .tick_44k1_i (tick_44k1),
            .tick_48k_i  (tick_48k),
            .tick_o      (tick)
        );

        bres_accum u_acc (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (clr),
            .tick_i   (tick),
            .cfg_i    (cfg),
            .strobe_o (strobe_o[g])
        );
    end
endmodule

// File: tb/bres_clkgen_tb.sv
module bres_clkgen_tb_top;
    localparam int NG = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] cfg_wr = '0;
    logic          cfg_sel = 1'b0;
    logic [31:0]   cfg_word = '0;
    logic          tick_44k1 = 1'b0;
    logic          tick_48k = 1'b0;
    logic [NG-1:0] strobe_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state, built from the requirements
    int m_inc[NG];
    int m_mod[NG];
    int m_acc[NG];
    bit m_sel[NG];

    always #10 clk = ~clk;   // 50 MHz

    bres_clkgen #(.NUM_GEN(NG)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_word(cfg_word), .tick_44k1(tick_44k1), .tick_48k(tick_48k),
        .strobe_o(strobe_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: strobe got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input int ch, input bit sel, input int inc, input int md);
        @(negedge clk);
        cfg_wr   = NG'(1) << ch;
        cfg_sel  = sel;
        cfg_word = {16'((inc - md - 1) & 16'hffff), 16'(inc)};
        @(negedge clk);
        cfg_wr   = '0;
        m_inc[ch] = inc; m_mod[ch] = md; m_acc[ch] = 0; m_sel[ch] = sel;
    endtask

    function automatic bit model_tick(input int ch, input bit t441, input bit t48);
        bit t;
        t = m_sel[ch] ? t441 : t48;
        if (!t || m_inc[ch] == 0) return 0;
        if (m_mod[ch] < m_inc[ch]) begin m_acc[ch] = 0; return 1; end
        m_acc[ch] += m_inc[ch];
        if (m_acc[ch] >= m_mod[ch]) begin m_acc[ch] -= m_mod[ch]; return 1; end
        return 0;
    endfunction

    // one tick cycle, then an idle cycle to confirm the strobe is a single pulse
    task automatic do_tick(input bit t441, input bit t48, input string req);
        bit e0, e1;
        @(negedge clk);
        tick_44k1 = t441; tick_48k = t48;
        e0 = model_tick(0, t441, t48);
        e1 = model_tick(1, t441, t48);
        @(negedge clk);
        tick_44k1 = 0; tick_48k = 0;
        check(req, strobe_o[0], e0);
        check(req, strobe_o[1], e1);
        @(negedge clk);
        check({req, " R5 single"}, strobe_o[0], 1'b0);
        check({req, " R5 single"}, strobe_o[1], 1'b0);
    endtask

    task automatic t_reset();
        for (int ch = 0; ch < NG; ch++) begin
            m_inc[ch] = 0; m_mod[ch] = 0; m_acc[ch] = 0; m_sel[ch] = 0;
        end
        check("R1 ch0", strobe_o[0], 1'b0);
        check("R1 ch1", strobe_o[1], 1'b0);
        for (int i = 0; i < 4; i++) do_tick(1, 1, "R1/R8 unwritten");
    endtask

    task automatic t_integer_ratio();
        int cnt = 0;
        write_cfg(0, 0, 4, 24);
        for (int i = 0; i < 30; i++) begin
            do_tick(0, 1, "R2/R4 48k/8k");
            if (strobe_o[0] === 1'b0) cnt = cnt;
        end
    endtask

    task automatic t_fractional();
        int seen = 0;
        write_cfg(1, 1, 4, 5);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            tick_44k1 = 1;
            void'(model_tick(0, 1, 0));
            if (model_tick(1, 1, 0)) seen++;
            @(negedge clk);
            tick_44k1 = 0;
            if (strobe_o[1] === 1'b1) seen--;
        end
        n_chk++;
        if (seen != 0) begin
            n_bad++;
            $display("FAIL R4 fractional count: diff %0d expected 0 (16 strobes in 20 ticks)", seen);
        end
        write_cfg(1, 1, 4, 5);
        for (int i = 0; i < 10; i++) do_tick(1, 0, "R4 fractional pattern");
    endtask

    task automatic t_wrong_ref();
        write_cfg(0, 1, 4, 4);
        for (int i = 0; i < 5; i++) do_tick(0, 1, "R3 other ref ignored");
        do_tick(1, 0, "R3 selected ref counts");
    endtask

    task automatic t_clear();
        write_cfg(0, 0, 4, 24);
        for (int i = 0; i < 5; i++) do_tick(0, 1, "R6 pre");
        write_cfg(0, 0, 4, 24);
        do_tick(0, 1, "R6 cleared acc no strobe");
        for (int i = 0; i < 5; i++) do_tick(0, 1, "R6 post");
        // tick in the write cycle is ignored
        @(negedge clk);
        cfg_wr = 2'b01; cfg_sel = 0; cfg_word = {16'((4 - 4 - 1) & 16'hffff), 16'd4};
        tick_48k = 1;
        @(negedge clk);
        cfg_wr = '0; tick_48k = 0;
        m_inc[0] = 4; m_mod[0] = 4; m_acc[0] = 0; m_sel[0] = 0;
        check("R6 tick during write", strobe_o[0], 1'b0);
        do_tick(0, 1, "R6 after write mod==inc");
    endtask

    task automatic t_degen();
        write_cfg(0, 0, 4, 2);
        for (int i = 0; i < 6; i++) do_tick(0, 1, "R7 mod<inc");
        write_cfg(0, 0, 4, 8);
        do_tick(0, 1, "R7 back normal");
        do_tick(0, 1, "R7 back normal");
    endtask

    task automatic t_idle();
        write_cfg(1, 0, 0, 10);
        for (int i = 0; i < 6; i++) do_tick(1, 1, "R8 inc zero");
    endtask

    task automatic t_independent();
        write_cfg(0, 0, 4, 24);
        write_cfg(1, 1, 4, 16);
        for (int i = 0; i < 24; i++) do_tick(i % 2 == 0, 1, "R9 two channels");
        write_cfg(1, 1, 4, 16);
        for (int i = 0; i < 6; i++) do_tick(0, 1, "R9 ch0 unaffected");
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_integer_ratio();
        t_fractional();
        t_wrong_ref();
        t_clear();
        t_degen();
        t_idle();
        t_independent();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule